// File: doc/BRIEF.md
# Flash Region Chip-Select Decoder

This block sits between a flash access engine and the pins of a serial-flash controller. It splits one flat address window, which starts at a fixed base, across up to four flash devices. The devices sit on two buses, and each bus has two chip selects. Software writes one upper-limit register per device. The devices are kept in a fixed order: bus A first device, bus A second device, bus B first device, bus B second device. Device 0's region starts at the window base. Every later device's region starts at the limit of the device before it. The region ends, exclusive, at the device's own limit. When a device's limit equals the limit before it, the device owns no addresses and the decoder passes over it.

For each access request, the block registers a one-hot device select, the bus number, the chip-select number within that bus, and the byte offset of the address inside the chosen region. An address below the base, or at or above every limit, raises a miss flag and selects nothing. At reset every limit equals the base, so no device is reachable until software programs at least one limit.

Top module: `flash_region_decoder`

## Requirements
- R1: After reset all four limits equal MEM_BASE, all outputs are 0, and every request is answered with rspMiss=1.
- R2: A cycle with cfgWrEn=1 loads cfgWrData into the limit chosen by cfgWrSel (0 = bus A device 0, 1 = bus A device 1, 2 = bus B device 0, 3 = bus B device 1). Requests from the next cycle on see the new value. A request in the same cycle as the write is decoded with the old value.
- R3: A request is served by the lowest-indexed device whose limit is strictly greater than reqAddr, provided reqAddr >= MEM_BASE. rspSel then has exactly bit i set, where i is that device index.
- R4: For the selected device i, rspBus = i / 2 (0 = bus A, 1 = bus B) and rspCs = i % 2.
- R5: rspOffset = reqAddr minus the region start. The region start is MEM_BASE for device 0 and the limit of device i-1 for any other device i.
- R6: A device whose limit equals the previous limit (or MEM_BASE, for device 0) is never selected. Addresses pass on to a later device.
- R7: When reqAddr < MEM_BASE or no limit exceeds reqAddr, the response has rspMiss=1 with rspSel, rspBus, rspCs and rspOffset all 0.
- R8: The response appears in the cycle after reqValid, with rspValid=1. In any cycle that follows a cycle without a request, rspValid, rspSel and rspMiss are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Limit register write strobe |
| cfgWrSel | input | 2 | Index of the limit register to write |
| cfgWrData | input | 24 | New limit value (exclusive upper address) |
| reqValid | input | 1 | Access request strobe |
| reqAddr | input | 24 | Access address in the flat window |
| rspValid | output | 1 | Decoded response valid |
| rspSel | output | 4 | One-hot device select |
| rspBus | output | 1 | Selected bus, 0 = A, 1 = B |
| rspCs | output | 1 | Chip select within the selected bus |
| rspOffset | output | 24 | Address relative to the start of the selected region |
| rspMiss | output | 1 | Address is outside every programmed region |

## Verification
On every cycle, the assertions check the following:
- At most one device is selected, and a miss never comes with a select.
- The bus and chip-select numbers agree with the select bit that is set.
- Nothing is selected or missed without a request in the cycle before.

The assertions cannot show that the right device won, that the offset is correct, or that an empty region was skipped. Only the bench's scenarios can show these: random sorted limit sets with deliberately repeated limits, exact boundary addresses, addresses below the base, and a write that collides with a request in the same cycle. Each of these is compared against a separately computed model.

// File: rtl/frd_pkg.sv
package frd_pkg;
  typedef struct packed {
    logic capture;  // decode the current request into the response registers
    logic load;     // write the selected limit register
  } frdStrobes_t;
endpackage

// File: rtl/frd_ctrl.sv
module frd_ctrl
  import frd_pkg::*;
#(
  parameter int NUM_DEV = 4,
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic [IDX_W-1:0] cfgWrSel,
  input  logic             reqValid,
  output frdStrobes_t      strb,
  output logic             rspValid
);
  always_comb begin
    strb.capture = reqValid;
    strb.load    = cfgWrEn && (32'(cfgWrSel) < NUM_DEV);
  end

  always_ff @(posedge clk) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= reqValid;
  end

  // R8: response valid follows a request by exactly one cycle
  assert_valid_latency_R8: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);
  assert_valid_idle_R8: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);
endmodule

// File: rtl/frd_path.sv
module frd_path
  import frd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] MEM_BASE = 24'h10_0000,
  parameter int NUM_BUS = 2,
  parameter int CS_PER_BUS = 2,
  localparam int NUM_DEV = NUM_BUS * CS_PER_BUS,
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int BUS_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
  localparam int CS_W  = (CS_PER_BUS > 1) ? $clog2(CS_PER_BUS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  frdStrobes_t        strb,
  input  logic [IDX_W-1:0]   wrSel,
  input  logic [ADDR_W-1:0]  wrData,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic [NUM_DEV-1:0] rspSel,
  output logic [BUS_W-1:0]   rspBus,
  output logic [CS_W-1:0]    rspCs,
  output logic [ADDR_W-1:0]  rspOffset,
  output logic               rspMiss
);
  logic [ADDR_W-1:0] bound [NUM_DEV];
  logic [NUM_DEV-1:0] below;

  // One limit register and one comparator per device
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_dev
    always_ff @(posedge clk) begin
      if (!rstN)
        bound[g] <= MEM_BASE;
      else if (strb.load && (wrSel == IDX_W'(g)))
        bound[g] <= wrData;
    end
    assign below[g] = reqAddr < bound[g];
  end

  logic              found;
  logic [IDX_W-1:0]  winIdx;
  logic [ADDR_W-1:0] regStart;
  logic [ADDR_W-1:0] prevTop;
  logic              inWindow;

  // Priority scan: the first limit above the address wins, and its start is
  // the limit before it
  always_comb begin
    found    = 1'b0;
    winIdx   = '0;
    regStart = MEM_BASE;
    prevTop  = MEM_BASE;
    for (int i = 0; i < NUM_DEV; i++) begin
      if (!found && below[i]) begin
        found    = 1'b1;
        winIdx   = IDX_W'(i);
        regStart = prevTop;
      end
      prevTop = bound[i];
    end
    inWindow = reqAddr >= MEM_BASE;
  end

  logic hitNow;
  assign hitNow = found && inWindow;

  always_ff @(posedge clk) begin
    if (!rstN || !strb.capture) begin
      rspSel    <= '0;
      rspBus    <= '0;
      rspCs     <= '0;
      rspOffset <= '0;
      rspMiss   <= 1'b0;
    end else if (hitNow) begin
      rspSel    <= NUM_DEV'(1) << winIdx;
      rspBus    <= BUS_W'(32'(winIdx) / CS_PER_BUS);
      rspCs     <= CS_W'(32'(winIdx) % CS_PER_BUS);
      rspOffset <= reqAddr - regStart;
      rspMiss   <= 1'b0;
    end else begin
      rspSel    <= '0;
      rspBus    <= '0;
      rspCs     <= '0;
      rspOffset <= '0;
      rspMiss   <= 1'b1;
    end
  end

  // R3: never more than one device selected
  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(rspSel));
  // R7: a miss carries no select and no offset
  assert_miss_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspMiss |-> (rspSel == '0 && rspOffset == '0));
  // R8: nothing is driven after a cycle without a request
  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> (rspSel == '0 && !rspMiss));
  // R4: bus and chip-select numbers agree with the select bit
  for (genvar g = 0; g < NUM_DEV; g++) begin : g_chk
    assert_bus_cs_R4: assert property (@(posedge clk) disable iff (!rstN)
      rspSel[g] |-> (rspBus == BUS_W'(g / CS_PER_BUS) && rspCs == CS_W'(g % CS_PER_BUS)));
  end
endmodule

// File: rtl/flash_region_decoder.sv
module flash_region_decoder
  import frd_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter logic [ADDR_W-1:0] MEM_BASE = 24'h10_0000,
  parameter int NUM_BUS = 2,
  parameter int CS_PER_BUS = 2,
  localparam int NUM_DEV = NUM_BUS * CS_PER_BUS,
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int BUS_W = (NUM_BUS > 1) ? $clog2(NUM_BUS) : 1,
  localparam int CS_W  = (CS_PER_BUS > 1) ? $clog2(CS_PER_BUS) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic [IDX_W-1:0]   cfgWrSel,
  input  logic [ADDR_W-1:0]  cfgWrData,
  input  logic               reqValid,
  input  logic [ADDR_W-1:0]  reqAddr,
  output logic               rspValid,
  output logic [NUM_DEV-1:0] rspSel,
  output logic [BUS_W-1:0]   rspBus,
  output logic [CS_W-1:0]    rspCs,
  output logic [ADDR_W-1:0]  rspOffset,
  output logic               rspMiss
);
  frdStrobes_t strb;

  frd_ctrl #(.NUM_DEV(NUM_DEV)) u_ctrl (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .reqValid(reqValid), .strb(strb), .rspValid(rspValid)
  );

  frd_path #(.ADDR_W(ADDR_W), .MEM_BASE(MEM_BASE), .NUM_BUS(NUM_BUS),
             .CS_PER_BUS(CS_PER_BUS)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .wrSel(cfgWrSel), .wrData(cfgWrData),
    .reqAddr(reqAddr), .rspSel(rspSel), .rspBus(rspBus), .rspCs(rspCs),
    .rspOffset(rspOffset), .rspMiss(rspMiss)
  );

  // R8: a select or a miss only ever comes with a valid response
  assert_out_needs_valid_R8: assert property (@(posedge clk) disable iff (!rstN)
    (rspSel != '0 || rspMiss) |-> rspValid);
  // R7: a valid response either selects a device or reports a miss
  assert_resp_decided_R7: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |-> ((rspSel != '0) != rspMiss));
endmodule

// File: tb/flash_region_decoder_bench.sv
module flash_region_decoder_bench;
  localparam int AW = 24;
  localparam logic [AW-1:0] BASE = 24'h10_0000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWrEn = 1'b0;
  logic [1:0] cfgWrSel = '0;
  logic [AW-1:0] cfgWrData = '0;
  logic reqValid = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic rspValid, rspBus, rspCs, rspMiss;
  logic [3:0] rspSel;
  logic [AW-1:0] rspOffset;

  int checks = 0;
  int fails = 0;
  logic [AW-1:0] mTop [4];

  always #10 clk = ~clk;

  flash_region_decoder u_flash_region_decoder (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrSel(cfgWrSel),
    .cfgWrData(cfgWrData), .reqValid(reqValid), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspSel(rspSel), .rspBus(rspBus), .rspCs(rspCs),
    .rspOffset(rspOffset), .rspMiss(rspMiss)
  );

  // packed response: {valid, sel[3:0], bus, cs, miss, offset[23:0]}
  function automatic logic [31:0] model(input logic [AW-1:0] a);
    logic [AW-1:0] start = BASE;
    if (a >= BASE) begin
      for (int i = 0; i < 4; i++) begin
        if (a < mTop[i])
          return {1'b1, 4'(1 << i), 1'(i / 2), 1'(i % 2), 1'b0, a - start};
        start = mTop[i];
      end
    end
    return {1'b1, 4'b0, 1'b0, 1'b0, 1'b1, 24'h0};
  endfunction

  function automatic logic [31:0] actual();
    return {rspValid, rspSel, rspBus, rspCs, rspMiss, rspOffset};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic writeTop(input int idx, input logic [AW-1:0] v);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrSel = 2'(idx); cfgWrData = v;
    @(negedge clk);
    cfgWrEn = 1'b0;
    mTop[idx] = v;
  endtask

  task automatic request(input string tag, input logic [AW-1:0] a);
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    check(tag, actual(), model(a));
  endtask

  task automatic setTops(input logic [AW-1:0] t0, input logic [AW-1:0] t1,
                         input logic [AW-1:0] t2, input logic [AW-1:0] t3);
    writeTop(0, t0); writeTop(1, t1); writeTop(2, t2); writeTop(3, t3);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < 4; i++) mTop[i] = BASE;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset outputs idle, every address misses
    check("R1 reset outputs", actual(), 32'h0);
    request("R1 reset miss at base", BASE);
    request("R1 reset miss high", BASE + 24'h400);

    // R8: idle cycle after a response
    @(negedge clk);
    check("R8 idle after response", actual(), 32'h0);

    // Contiguous regions of 0x100 each
    setTops(BASE + 24'h100, BASE + 24'h200, BASE + 24'h300, BASE + 24'h400);
    request("R3 first device at base", BASE);
    request("R3 boundary goes to next", BASE + 24'h100);
    request("R5 offset last byte dev1", BASE + 24'h1ff);
    request("R4 bus B cs1", BASE + 24'h350);
    request("R4 bus B cs0", BASE + 24'h2a0);
    request("R7 at last limit", BASE + 24'h400);
    request("R7 below base", BASE - 24'h1);

    // R6: bus A devices empty, traffic goes to bus B
    setTops(BASE, BASE, BASE + 24'h80, BASE + 24'h80);
    request("R6 empty regions skipped", BASE);
    request("R6 empty dev3 not chosen", BASE + 24'h80);
    request("R6 offset from base", BASE + 24'h7f);

    // R2: write and request in the same cycle use the old limit
    @(negedge clk);
    cfgWrEn = 1'b1; cfgWrSel = 2'd3; cfgWrData = BASE + 24'h200;
    reqValid = 1'b1; reqAddr = BASE + 24'h100;
    @(negedge clk);
    cfgWrEn = 1'b0; reqValid = 1'b0;
    check("R2 same-cycle write uses old limit", actual(), model(BASE + 24'h100));
    mTop[3] = BASE + 24'h200;
    request("R2 new limit next cycle", BASE + 24'h100);

    // Random sorted limit sets, some repeated, random addresses
    for (int set = 0; set < 40; set++) begin
      logic [AW-1:0] t;
      t = BASE;
      for (int i = 0; i < 4; i++) begin
        if ($urandom_range(3) != 0) t = t + AW'($urandom_range(24'h400, 1));
        writeTop(i, t);
      end
      for (int k = 0; k < 25; k++) begin
        logic [AW-1:0] a;
        a = BASE - 24'h10 + AW'($urandom_range(int'(t - BASE) + 24'h20, 0));
        request("R3 R4 R5 R6 R7 random", a);
      end
      request("R7 random at last limit", t);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule